// File: doc/BRIEF.md
# Write-Protect Command Sequence Unlocker

This block sits between a host's write strobes and the write controller of a byte-wide nonvolatile memory. Each accepted host write is either a step of a fixed address/data command sequence or ordinary data. Command steps are consumed and are never passed to the array. Data writes are passed on through a one-cycle commit port, or they are blocked, depending on the protection state.

Writes are grouped into load windows. A window opens on the first write accepted while the block is idle. Each accepted write restarts the window's idle timer. When the timer runs out, the block starts a timed program cycle and reports busy for its full length. If no byte was committed during the window, the program cycle is flagged as a dummy.

The protection flag has its own clear input. The ordinary reset does not change it, and it is only updated at the end of a program cycle that follows a completed command sequence.

Top module: `wpu_guard`

## Requirements
- R1: While `rst_n` is low, `commit_vld`, `prog_start`, `prog_dummy` and `busy` are 0. A low `init_n` clears `protect` to 0, which is the initial unprotected state.
- R2: The enable sequence is three accepted writes in one window: 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Only the low 15 address bits are compared. Its writes never assert `commit_vld`.
- R3: A write that does not match the next expected step is treated as data, and matching restarts from the first step. A non-command value written to a command address is ordinary data.
- R4: While unprotected, an accepted data write gives `commit_vld` high for exactly one cycle after the strobe edge, with `commit_addr` and `commit_data` equal to the written values.
- R5: A window closes LOAD_CYC cycles after its last accepted write. `prog_start` then pulses and `busy` stays high for PROG_CYC cycles. Strobes while `busy` is high are ignored: they produce no commit and do not advance the matcher.
- R6: After an enable sequence, `protect` becomes 1 on the same edge on which `busy` falls, and not before.
- R7: While protected, a data write in a window with no completed enable sequence is not committed. The window still ends with `prog_start` and `prog_dummy` high and a full busy cycle.
- R8: While protected, data writes that follow a completed enable sequence in the same window are committed, and that window's `prog_dummy` is 0.
- R9: The disable sequence is six writes: 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, 0x20/0x5555. After it, `protect` becomes 0 on the edge on which `busy` falls.
- R10: A pulse on `rst_n` leaves `protect` unchanged.
- R11: `prog_dummy` is high together with `prog_start` exactly when the closing window committed no byte. This includes windows that held only command writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for everything except the protect flag |
| init_n | input | 1 | Asynchronous active-low clear of the protect flag |
| wr_stb | input | 1 | Host write strobe, one cycle per byte |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| commit_vld | output | 1 | Byte forwarded to the array load |
| commit_addr | output | ADDR_W | Address of the forwarded byte |
| commit_data | output | 8 | Forwarded byte |
| prog_start | output | 1 | Pulse: window closed, program cycle begins |
| prog_dummy | output | 1 | With prog_start: the cycle stores nothing |
| busy | output | 1 | Program cycle in progress |
| protect | output | 1 | Software write protection active |

## Verification
Two events can fall in the same cycle. The first case is a strobe on the last idle cycle before the window would expire: it must extend the window rather than race the program start. The second case is a strobe on the last busy cycle, the cycle in which protection changes: that strobe must be dropped. The bench places writes exactly at these boundaries. A behavioural model tracks windows, busy time, the sequence position and the pending protection change, and every output is compared against it on every clock.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
    localparam int CMD_AW = 15;
    localparam logic [CMD_AW-1:0] CMD_ADDR_HI = 15'h5555;
    localparam logic [CMD_AW-1:0] CMD_ADDR_LO = 15'h2AAA;
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_LOCK    = 8'hA0;
    localparam logic [7:0] OP_EXTEND  = 8'h80;
    localparam logic [7:0] OP_FREE    = 8'h20;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_GOT1,
        SEQ_GOT2,
        SEQ_GOT3,
        SEQ_GOT4,
        SEQ_GOT5
    } seq_step_e;
endpackage

// File: rtl/wpu_seq_match.sv
module wpu_seq_match
    import wpu_pkg::*;
(
    input  seq_step_e         step_i,
    input  logic [CMD_AW-1:0] addr_i,
    input  logic [7:0]        data_i,
    output seq_step_e         next_o,
    output logic              consumed_o,
    output logic              en_done_o,
    output logic              dis_done_o
);
    logic at_hi, at_lo;

    always_comb begin
        at_hi      = (addr_i == CMD_ADDR_HI);
        at_lo      = (addr_i == CMD_ADDR_LO);
        next_o     = SEQ_IDLE;
        consumed_o = 1'b0;
        en_done_o  = 1'b0;
        dis_done_o = 1'b0;
        unique case (step_i)
            SEQ_IDLE, SEQ_GOT3: begin
                if (at_hi && data_i == KEY_FIRST) begin
                    consumed_o = 1'b1;
                    next_o     = (step_i == SEQ_IDLE) ? SEQ_GOT1 : SEQ_GOT4;
                end
            end
            SEQ_GOT1, SEQ_GOT4: begin
                if (at_lo && data_i == KEY_SECOND) begin
                    consumed_o = 1'b1;
                    next_o     = (step_i == SEQ_GOT1) ? SEQ_GOT2 : SEQ_GOT5;
                end
            end
            SEQ_GOT2: begin
                if (at_hi && data_i == OP_LOCK) begin
                    consumed_o = 1'b1;
                    en_done_o  = 1'b1;
                end else if (at_hi && data_i == OP_EXTEND) begin
                    consumed_o = 1'b1;
                    next_o     = SEQ_GOT3;
                end
            end
            SEQ_GOT5: begin
                if (at_hi && data_i == OP_FREE) begin
                    consumed_o = 1'b1;
                    dis_done_o = 1'b1;
                end
            end
            default: next_o = SEQ_IDLE;
        endcase
    end
endmodule

// File: rtl/wpu_cycle_timer.sv
module wpu_cycle_timer #(
    parameter int LOAD_CYC = 30000,
    parameter int PROG_CYC = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    output logic window_o,
    output logic busy_o,
    output logic close_o,
    output logic done_o
);
    localparam int CNT_MAX = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LOAD_LAST = CW'(LOAD_CYC - 1);
    localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYC - 1);

    typedef struct packed {
        logic          win;
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        close_o = 1'b0;
        done_o  = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == PROG_LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                done_o    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (stb_i) begin
            st_d.win = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.win) begin
            if (st_q.cnt == LOAD_LAST) begin
                st_d.win  = 1'b0;
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                close_o   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign window_o = st_q.win;
    assign busy_o   = st_q.busy;

    // R5
    win_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.win && st_q.busy));

    // R5
    busy_from_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(st_q.win));
endmodule

// File: rtl/wpu_guard.sv
module wpu_guard
    import wpu_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int LOAD_CYC = 30000,
    parameter int PROG_CYC = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              commit_vld,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [7:0]        commit_data,
    output logic              prog_start,
    output logic              prog_dummy,
    output logic              busy,
    output logic              protect
);
    typedef struct packed {
        seq_step_e         step;
        logic              unlock;
        logic              wrote;
        logic              pend_v;
        logic              pend_val;
        logic              cvld;
        logic [ADDR_W-1:0] caddr;
        logic [7:0]        cdata;
        logic              pstart;
        logic              pdummy;
    } guard_st_t;

    guard_st_t st_d, st_q;
    logic      protect_d, protect_q;
    logic      accept, win, busy_w, close, done;
    seq_step_e m_next;
    logic      m_cons, m_en, m_dis;

    assign accept = wr_stb && !busy_w;

    wpu_cycle_timer #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_i    (accept),
        .window_o (win),
        .busy_o   (busy_w),
        .close_o  (close),
        .done_o   (done)
    );

    wpu_seq_match match_i (
        .step_i     (st_q.step),
        .addr_i     (wr_addr[CMD_AW-1:0]),
        .data_i     (wr_data),
        .next_o     (m_next),
        .consumed_o (m_cons),
        .en_done_o  (m_en),
        .dis_done_o (m_dis)
    );

    always_comb begin
        st_d        = st_q;
        protect_d   = protect_q;
        st_d.cvld   = 1'b0;
        st_d.pstart = 1'b0;
        st_d.pdummy = 1'b0;
        if (accept) begin
            if (m_cons) begin
                st_d.step = m_next;
                if (m_en) begin
                    st_d.pend_v   = 1'b1;
                    st_d.pend_val = 1'b1;
                    if (protect_q) st_d.unlock = 1'b1;
                end
                if (m_dis) begin
                    st_d.pend_v   = 1'b1;
                    st_d.pend_val = 1'b0;
                end
            end else begin
                st_d.step = SEQ_IDLE;
                if (!protect_q || st_q.unlock) begin
                    st_d.cvld  = 1'b1;
                    st_d.caddr = wr_addr;
                    st_d.cdata = wr_data;
                    st_d.wrote = 1'b1;
                end
            end
        end
        if (close) begin
            st_d.pstart = 1'b1;
            st_d.pdummy = !st_q.wrote;
            st_d.step   = SEQ_IDLE;
            st_d.unlock = 1'b0;
            st_d.wrote  = 1'b0;
        end
        if (done && st_q.pend_v) begin
            protect_d   = st_q.pend_val;
            st_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) protect_q <= 1'b0;
        else         protect_q <= protect_d;
    end

    assign commit_vld  = st_q.cvld;
    assign commit_addr = st_q.caddr;
    assign commit_data = st_q.cdata;
    assign prog_start  = st_q.pstart;
    assign prog_dummy  = st_q.pdummy;
    assign busy        = busy_w;
    assign protect     = protect_q;

    // R5
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && busy) |=> !commit_vld);

    // R6
    prot_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        (protect != $past(protect)) |-> ($past(busy) && !busy));

    // R7
    locked_commit_chk: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        commit_vld |-> ($past(!protect) || $past(st_q.unlock)));

    // R11
    dummy_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_dummy |-> prog_start);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (busy && !commit_vld));

    // R4
    commit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> win);
endmodule

// File: tb/wpu_guard_tb.sv
module wpu_guard_tb_top;
    localparam int AW   = 19;
    localparam int LOAD = 6;
    localparam int PROG = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          commit_vld, prog_start, prog_dummy, busy, protect;
    logic [AW-1:0] commit_addr;
    logic [7:0]    commit_data;

    always #2.5 clk = ~clk;

    wpu_guard #(.ADDR_W(AW), .LOAD_CYC(LOAD), .PROG_CYC(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_n(init_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_vld(commit_vld), .commit_addr(commit_addr), .commit_data(commit_data),
        .prog_start(prog_start), .prog_dummy(prog_dummy), .busy(busy), .protect(protect)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    string cur = "R1";

    // reference model state
    int m_prot = 0, m_left = 0, m_idle = 0, m_win = 0, m_step = 0;
    int m_unlock = 0, m_wrote = 0, m_pend = -1;
    int e_cv = 0, e_ca = 0, e_cd = 0, e_ps = 0, e_pd = 0;
    int seq_a [6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
    int seq_d [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        int lo;
        e_cv = 0; e_ps = 0; e_pd = 0;
        if (!init_n) m_prot = 0;
        if (!rst_n) begin
            m_left = 0; m_win = 0; m_idle = 0; m_step = 0;
            m_unlock = 0; m_wrote = 0; m_pend = -1;
            return;
        end
        if (m_left > 0) begin
            m_left--;
            if (m_left == 0 && m_pend >= 0) begin
                m_prot = m_pend;
                m_pend = -1;
            end
        end else if (wr_stb) begin
            m_win = 1; m_idle = 0;
            lo = int'(wr_addr[14:0]);
            if (m_step == 2 && lo == 'h5555 && wr_data == 8'hA0) begin
                m_step = 0; m_pend = 1;
                if (m_prot != 0) m_unlock = 1;
            end else if (lo == seq_a[m_step] && int'(wr_data) == seq_d[m_step]) begin
                m_step++;
                if (m_step == 6) begin m_step = 0; m_pend = 0; end
            end else begin
                m_step = 0;
                if (m_prot == 0 || m_unlock != 0) begin
                    e_cv = 1; e_ca = int'(wr_addr); e_cd = int'(wr_data); m_wrote = 1;
                end
            end
        end else if (m_win != 0) begin
            m_idle++;
            if (m_idle == LOAD) begin
                e_ps = 1; e_pd = (m_wrote == 0);
                m_left = PROG; m_win = 0; m_step = 0; m_unlock = 0; m_wrote = 0;
            end
        end
    endtask

    task automatic compare();
        check_eq(cur, "commit_vld", int'(commit_vld), e_cv);
        if (e_cv != 0) begin
            check_eq(cur, "commit_addr", int'(commit_addr), e_ca);
            check_eq(cur, "commit_data", int'(commit_data), e_cd);
        end
        check_eq(cur, "prog_start", int'(prog_start), e_ps);
        check_eq(cur, "prog_dummy", int'(prog_dummy), e_pd);
        check_eq(cur, "busy", int'(busy), int'(m_left > 0));
        check_eq(cur, "protect", int'(protect), m_prot);
    endtask

    task automatic step_clk();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step_clk();
    endtask

    task automatic wr(int a, int d);
        wr_stb = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
        step_clk();
        wr_stb = 1'b0;
    endtask

    task automatic enable_seq();
        wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'hA0);
    endtask

    initial begin
        // R1: reset state
        cur = "R1";
        idle(3);
        check_eq("R1", "protect after init", int'(protect), 0);
        check_eq("R1", "busy in reset", int'(busy), 0);
        init_n = 1'b1; rst_n = 1'b1;
        idle(2);

        // R4: unprotected data writes
        cur = "R4";
        wr('h01234, 'h3C); wr('h01235, 'h5A);
        idle(LOAD + PROG + 2);

        // R3: data to a command address, and a broken prefix
        cur = "R3";
        wr('h5555, 'h12);
        wr('h5555, 'hAA); wr('h00100, 'h77);
        wr('h2AAA, 'h55);
        idle(LOAD + PROG + 2);

        // R5: window boundary, strobe on last idle cycle extends
        cur = "R5";
        wr('h00010, 'h01);
        idle(LOAD - 1);
        wr('h00011, 'h02);
        idle(LOAD + 1);
        wr('h5555, 'hAA);         // during busy: dropped
        idle(PROG - 3);
        wr('h00012, 'h03);        // last busy cycle: dropped
        wr('h2AAA, 'h55);         // must be data, matcher untouched
        idle(LOAD + PROG + 2);

        // R2 / R6 / R11: enable alone, dummy program, protect at busy end
        cur = "R2";
        enable_seq();
        cur = "R6";
        idle(LOAD + 1);
        check_eq("R6", "protect during busy", int'(protect), 0);
        idle(PROG);
        check_eq("R6", "protect after busy", int'(protect), 1);
        cur = "R11";
        idle(2);

        // R7: locked write
        cur = "R7";
        wr('h00200, 'h99);
        idle(LOAD + PROG + 2);

        // R8: prefixed write while protected
        cur = "R8";
        enable_seq();
        wr('h00300, 'h11); wr('h00301, 'h22);
        idle(LOAD + PROG + 2);
        check_eq("R8", "still protected", int'(protect), 1);

        // R10: reset pulse keeps protection
        cur = "R10";
        rst_n = 1'b0; step_clk(); rst_n = 1'b1; step_clk();
        check_eq("R10", "protect after rst_n", int'(protect), 1);

        // R9: disable sequence
        cur = "R9";
        wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h80);
        wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h20);
        idle(LOAD + PROG + 2);
        check_eq("R9", "protect cleared", int'(protect), 0);
        wr('h00400, 'h44);
        idle(LOAD + PROG + 2);

        // R1: init_n clears protection
        cur = "R1";
        enable_seq();
        idle(LOAD + PROG + 2);
        init_n = 1'b0; step_clk(); init_n = 1'b1; step_clk();
        check_eq("R1", "protect after init_n", int'(protect), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule